// File: doc/BRIEF.md
# Ping-Pong Audio Fetch Engine

This block streams audio samples from memory into a small word FIFO that feeds a serial audio transmitter. It fetches one Qword (four 32-bit words, 16 bytes) per burst over a request/grant read port. Two buffer slots, A and B, each hold a current pointer and a pointer to their last Qword. When the engine leaves the end of one slot, it moves to the other on its own and raises an interrupt. Software refills the drained slot while the other one plays, so the transmitter never runs out of data.

Software controls the block through a small register port. It reads back which slot is active, whether an interrupt is waiting, and whether the engine has fallen into a slot that was never refilled (overrun). A control bit stops or starts fetching, and a self-clearing control bit returns the fetch sequencer and its flags to their reset condition.

Top module: `pingpong_audio_dma`

## Requirements
- R1: After reset, status reads 0, control reads 0x10, `mem_req`, `out_valid` and `irq` are low.
- R2: Control register (offset 4): bit 5 is the enable and reads back as written, bit 4 always reads 1, and bit 7 reads 0. With the enable at 0 the block issues no memory request.
- R3: A burst is requested only while the FIFO has at least four free words. `mem_addr` carries the active slot's current pointer. Each grant advances that pointer by 16 bytes.
- R4: When a grant advances the active pointer past its last-Qword pointer, the active slot toggles and the pending flag is set. The pending flag drives `irq`. Status (offset 5) packs bit 0 = active slot (0 = A, 1 = B), bit 1 = pending, bit 2 = overrun.
- R5: Writing either last-Qword pointer clears the pending flag. A slot switch in the same cycle as that write leaves the flag set.
- R6: Overrun is set when the engine switches into a slot whose pointers have not been written since that slot was last drained. Overrun stays set through pointer writes until a clear.
- R7: Writing control with bit 7 = 1 makes the active slot A and clears pending, overrun and the refill marks. It also empties the FIFO and returns the sequencer to idle. Writing bit 7 = 0 changes none of these.
- R8: The four words returned by a burst enter the FIFO in arrival order. `out_data` presents them in that order, one per cycle in which `out_valid` and `out_ready` are both high.
- R9: Pointer registers sit at offsets 0 (A current), 1 (A last), 2 (B current) and 3 (B last). They hold byte addresses whose low four bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| mem_req | output | 1 | Burst read request, held until granted |
| mem_addr | output | AW | Byte address of the requested Qword |
| mem_gnt | input | 1 | Burst accepted |
| mem_rvalid | input | 1 | Read data beat valid |
| mem_rdata | input | 32 | Read data beat |
| out_valid | output | 1 | FIFO holds a word |
| out_data | output | 32 | Oldest FIFO word |
| out_ready | input | 1 | Transmitter takes the word |
| irq | output | 1 | Slot-finished interrupt |

## Verification
The delicate case is a grant that exhausts a slot in the same cycle as a last-Qword pointer write. The grant sets the pending flag and the write clears it. The bench waits until a request is pending. It then releases the grant and drives the pointer write on the same clock edge, and expects status to show the switch with pending still set. Separate scenarios cover the FIFO room limit, overrun into an unrefilled slot, and a clear write with bit 7 = 0 against one with bit 7 = 1.

// File: rtl/pingpong_audio_dma.sv
`timescale 1ns/1ps
module pingpong_audio_dma #(
  parameter int AW    = 32,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [2:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_gnt,
  input  logic          mem_rvalid,
  input  logic [31:0]   mem_rdata,
  output logic          out_valid,
  output logic [31:0]   out_data,
  input  logic          out_ready,
  output logic          irq
);
  localparam int QW = AW - 4;
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_DATA} st_t;
  st_t state;

  logic [QW-1:0] cur [2];
  logic [QW-1:0] lim [2];
  logic          act, pend, ovr, ena;
  logic [1:0]    stale;
  logic [1:0]    beat;
  logic [31:0]   fifo [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  wire ptr_wr   = reg_wr && !reg_addr[2];
  wire ctl_wr   = reg_wr && (reg_addr == 3'd4);
  wire clr      = ctl_wr && reg_wdata[7];
  wire push     = (state == S_DATA) && mem_rvalid;
  wire pop      = out_valid && out_ready;
  wire [QW-1:0] nq = cur[act] + 1'b1;
  wire done     = nq > lim[act];
  wire oth_wr   = ptr_wr && (reg_addr[1] == ~act);
  wire unused_wdata = ^{reg_wdata[6], reg_wdata[4], reg_wdata[3:0]};

  assign mem_req   = (state == S_REQ);
  assign mem_addr  = {cur[act], 4'b0000};
  assign out_valid = (cnt != '0);
  assign out_data  = fifo[rp];
  assign irq       = pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cur[0] <= '0; cur[1] <= '0; lim[0] <= '0; lim[1] <= '0;
      act <= 1'b0; pend <= 1'b0; ovr <= 1'b0; ena <= 1'b0;
      stale <= 2'b00; beat <= 2'd0;
    end else begin
      if (ptr_wr) begin
        if (reg_addr[0]) begin
          lim[reg_addr[1]] <= reg_wdata[AW-1:4];
          pend <= 1'b0;
        end else begin
          cur[reg_addr[1]] <= reg_wdata[AW-1:4];
        end
        stale[reg_addr[1]] <= 1'b0;
      end
      if (ctl_wr) ena <= reg_wdata[5];
      case (state)
        S_IDLE: if (ena && cnt <= CW'(DEPTH - 4)) state <= S_REQ;
        S_REQ: if (mem_gnt) begin
          state <= S_DATA;
          beat <= 2'd0;
          cur[act] <= nq;
          if (done) begin
            act <= ~act;
            pend <= 1'b1;
            stale[act] <= 1'b1;
            if (stale[~act] && !oth_wr) ovr <= 1'b1;
          end
        end
        default: if (mem_rvalid) begin
          beat <= beat + 2'd1;
          if (beat == 2'd3) state <= S_IDLE;
        end
      endcase
      if (clr) begin
        state <= S_IDLE; act <= 1'b0; pend <= 1'b0; ovr <= 1'b0; stale <= 2'b00;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else if (clr) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else begin
      if (push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      if (push && !pop) cnt <= cnt + 1'b1;
      else if (pop && !push) cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !clr) fifo[wp] <= mem_rdata;
  end

  always_comb begin
    case (reg_addr)
      3'd0: reg_rdata = 32'({cur[0], 4'b0000});
      3'd1: reg_rdata = 32'({lim[0], 4'b0000});
      3'd2: reg_rdata = 32'({cur[1], 4'b0000});
      3'd3: reg_rdata = 32'({lim[1], 4'b0000});
      3'd4: reg_rdata = {26'd0, ena, 1'b1, 4'b0000};
      3'd5: reg_rdata = {29'd0, ovr, pend, act};
      default: reg_rdata = {31'd0, unused_wdata & 1'b0};
    endcase
  end

  a_r3_room_before_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> cnt <= CW'(DEPTH - 4));
  a_r3_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt && !clr && !ptr_wr) |=> (mem_req && $stable(mem_addr)));
  a_r2_off_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == S_IDLE) && !ena) |=> !mem_req);
  a_r4_switch_on_grant: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act) |-> ($past(mem_gnt) || $past(clr)));
  a_r6_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && !clr) |=> ovr);
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> cnt < CW'(DEPTH));
endmodule

// File: tb/test_pingpong_audio_dma.sv
`timescale 1ns/1ps
module test_pingpong_audio_dma;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'd0, reg_rdata;
  logic mem_req, mem_gnt = 1'b0, mem_rvalid = 1'b0;
  logic [31:0] mem_addr, mem_rdata = 32'd0;
  logic out_valid, out_ready = 1'b0, irq;
  logic [31:0] out_data;

  int total = 0, bad = 0, cyc = 0;
  int beats = 0, gnt_cnt = 0, req_cnt = 0, ncap = 0;
  logic allow = 1'b0;
  logic [31:0] baddr = 32'd0;
  logic [31:0] gaddr [16];
  logic [31:0] cap [32];

  pingpong_audio_dma #(.AW(32), .DEPTH(8)) i_pingpong_audio_dma (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .out_valid(out_valid), .out_data(out_data),
    .out_ready(out_ready), .irq(irq));

  always #4 clk = ~clk;

  always @(negedge clk) begin
    mem_gnt <= 1'b0;
    mem_rvalid <= 1'b0;
    if (mem_req) req_cnt <= req_cnt + 1;
    if (out_valid && out_ready) begin
      if (ncap < 32) cap[ncap] <= out_data;
      ncap <= ncap + 1;
    end
    if (beats > 0) begin
      mem_rvalid <= 1'b1;
      mem_rdata <= baddr + 32'((4 - beats) * 4);
      beats <= beats - 1;
    end else if (allow && mem_req && !mem_gnt) begin
      mem_gnt <= 1'b1;
      baddr <= mem_addr;
      beats <= 4;
      if (gnt_cnt < 16) gaddr[gnt_cnt] <= mem_addr;
      gnt_cnt <= gnt_cnt + 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(posedge clk); #1 reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1 reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(posedge clk); #1 reg_addr = a;
    @(negedge clk); v = reg_rdata;
  endtask

  task automatic grant_one();
    int n = gnt_cnt;
    @(posedge clk); #1 allow = 1'b1;
    while (gnt_cnt == n) @(posedge clk);
    #1 allow = 1'b0;
    repeat (7) @(posedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(3'd5, v); check("R1 status", v, 32'd0);
    rd(3'd4, v); check("R1/R2 control", v, 32'h10);
    check("R1 mem_req", {31'd0, mem_req}, 32'd0);
    check("R1 out_valid", {31'd0, out_valid}, 32'd0);
    check("R1 irq", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    wr(3'd0, 32'h0000_100C); rd(3'd0, v); check("R9 low bits zero", v, 32'h1000);
    wr(3'd1, 32'h0000_1010); rd(3'd1, v); check("R9 A last", v, 32'h1010);
    wr(3'd2, 32'h0000_2000); wr(3'd3, 32'h0000_2000);
    rd(3'd3, v); check("R9 B last", v, 32'h2000);
  endtask

  task automatic t_disabled();
    int r0 = req_cnt;
    @(posedge clk); #1 allow = 1'b1;
    repeat (10) @(posedge clk);
    #1 allow = 1'b0;
    check("R2 no request while off", 32'(req_cnt - r0), 32'd0);
  endtask

  task automatic t_room();
    logic [31:0] v;
    out_ready = 1'b0;
    wr(3'd4, 32'h20);
    rd(3'd4, v); check("R2 enable readback", v, 32'h30);
    @(posedge clk); #1 allow = 1'b1;
    repeat (40) @(posedge clk);
    #1 allow = 1'b0;
    check("R3 two bursts fill FIFO", 32'(gnt_cnt), 32'd2);
    check("R3 first addr", gaddr[0], 32'h1000);
    check("R3 second addr", gaddr[1], 32'h1010);
    rd(3'd0, v); check("R3 A pointer advanced", v, 32'h1020);
    rd(3'd5, v); check("R4 switched to B, pending", v, 32'd3);
    check("R4 irq", {31'd0, irq}, 32'd1);
  endtask

  task automatic t_drain();
    int b = ncap;
    out_ready = 1'b1;
    repeat (15) @(posedge clk);
    check("R8 word count", 32'(ncap - b), 32'd8);
    for (int i = 0; i < 8; i++) check("R8 word order", cap[b + i], 32'h1000 + 32'(4 * i));
    check("R3 no burst without grant", 32'(gnt_cnt), 32'd2);
  endtask

  task automatic t_pend_clear();
    logic [31:0] v;
    wr(3'd3, 32'h2000);
    rd(3'd5, v); check("R5 end write clears pending", v, 32'd1);
    check("R5 irq low", {31'd0, irq}, 32'd0);
    wr(3'd0, 32'h1000); wr(3'd1, 32'h1000);
  endtask

  task automatic t_switch_back();
    logic [31:0] v;
    grant_one();
    check("R3 B burst addr", gaddr[2], 32'h2000);
    rd(3'd5, v); check("R4 back to A, no overrun", v, 32'd2);
  endtask

  task automatic t_overrun();
    logic [31:0] v;
    grant_one();
    check("R3 A burst addr", gaddr[3], 32'h1000);
    rd(3'd5, v); check("R6 overrun into stale B", v, 32'd7);
    grant_one();
    check("R3 B continues", gaddr[4], 32'h2010);
    rd(3'd5, v); check("R6 switch to stale A", v, 32'd6);
    wr(3'd1, 32'h1000);
    rd(3'd5, v); check("R6 overrun sticky over write", v, 32'd4);
  endtask

  task automatic t_clear();
    logic [31:0] v, s0;
    out_ready = 1'b0;
    grant_one();
    check("R8 FIFO holds words", {31'd0, out_valid}, 32'd1);
    rd(3'd5, s0);
    wr(3'd4, 32'h20);
    rd(3'd5, v); check("R7 bit7=0 no effect", v, s0);
    check("R7 bit7=0 keeps FIFO", {31'd0, out_valid}, 32'd1);
    wr(3'd4, 32'hA0);
    rd(3'd5, v); check("R7 clear status", v, 32'd0);
    check("R7 FIFO flushed", {31'd0, out_valid}, 32'd0);
    rd(3'd4, v); check("R7 control after clear", v, 32'h30);
  endtask

  task automatic t_same_cycle();
    logic [31:0] v;
    out_ready = 1'b1;
    wr(3'd0, 32'h1000); wr(3'd1, 32'h1000);
    wr(3'd2, 32'h2000); wr(3'd3, 32'h2000);
    repeat (3) @(posedge clk);
    #1 allow = 1'b1; reg_wr = 1'b1; reg_addr = 3'd3; reg_wdata = 32'h2000;
    @(posedge clk); #1 allow = 1'b0; reg_wr = 1'b0;
    repeat (6) @(posedge clk);
    check("R3 grant addr", gaddr[6], 32'h1000);
    rd(3'd5, v); check("R5 set wins over end write", v, 32'd3);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 50000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_regs();
    t_disabled();
    t_room();
    t_drain();
    t_pend_clear();
    t_switch_back();
    t_overrun();
    t_clear();
    t_same_cycle();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule